// File: doc/BRIEF.md
# Multi-Size Fully Associative Translation Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses using a small, fully associative set of translation entries. Each entry covers one of four region sizes: 4 KB, 64 KB, 1 MB or 16 MB. For each entry, only the address bits above that entry's offset take part in the compare. Software fills the entries one at a time through a load port. A replacement pointer picks the slot to write. The pointer advances in round-robin order after each load, and software may also set it directly. A single strobe invalidates every entry at once.

A lookup request is answered one clock later. The answer is a hit flag, the translated address and the index of the matching entry. When the lookup misses, the block raises a fault interrupt and stores the faulting virtual address. Both stay in place until software acknowledges the fault. Page-table walking and any bus access are left to logic outside this block.

Top module: `mpx_tlb`

## Requirements
- R1: After reset, no entry is valid, `victim_ptr` is 0, `fault_irq` is 0 and `lk_vld` is 0.
- R2: The `ld_size` code selects the offset width of an entry: 2'b00 gives 12 bits (4 KB), 2'b01 gives 16 (64 KB), 2'b10 gives 20 (1 MB) and 2'b11 gives 24 (16 MB). An entry hits when it is valid and `lk_vaddr` equals its stored virtual tag in every bit above the offset. Bits below the offset are ignored.
- R3: On a hit, `lk_paddr` takes its bits above the offset from the entry's physical base and its offset bits unchanged from `lk_vaddr`. On a miss, `lk_paddr` is 0.
- R4: A lookup requested in one cycle is reported at the next clock edge. At that edge `lk_vld` is high for one cycle, together with `lk_hit`, `lk_paddr` and `lk_idx`. `lk_idx` is 0 on a miss.
- R5: When several valid entries match, the entry with the lowest index wins, in both `lk_idx` and `lk_paddr`.
- R6: A load writes the entry at `victim_ptr`. The pointer then advances by one and wraps from NUM_ENTRIES-1 to 0.
- R7: A direct pointer write loads `vp_wr_idx` into `victim_ptr` and takes precedence over the advance. A load in the same cycle writes the slot at the old pointer.
- R8: `inv_all` clears every valid bit in one cycle. A load issued in the same cycle is discarded and does not advance the pointer.
- R9: On a miss, `fault_irq` rises at the same edge as the result. `fault_addr` then holds the missing virtual address.
- R10: `fault_irq` and `fault_addr` hold until `fault_clr` is asserted. Further misses while a fault is pending do not change `fault_addr`. A miss in the same cycle as `fault_clr` captures the new address and keeps the interrupt high.
- R11: An entry loaded with `ld_valid` = 0 never hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one entry at the replacement pointer |
| ld_vtag | input | 32 | Virtual tag of the entry (bits below its offset unused) |
| ld_pbase | input | 32 | Physical base of the entry (bits below its offset unused) |
| ld_size | input | 2 | Region size code |
| ld_valid | input | 1 | Valid bit of the entry |
| vp_wr_en | input | 1 | Set the replacement pointer directly |
| vp_wr_idx | input | IDX_W | New replacement pointer value |
| inv_all | input | 1 | Invalidate every entry |
| victim_ptr | output | IDX_W | Current replacement pointer |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_paddr | output | 32 | Translated physical address |
| lk_idx | output | IDX_W | Index of the winning entry |
| fault_irq | output | 1 | Pending translation fault |
| fault_addr | output | 32 | Captured faulting virtual address |
| fault_clr | input | 1 | Acknowledge the pending fault |

## Verification
The bench builds the block with NUM_ENTRIES = 8, so IDX_W is 3. At this size the replacement pointer wraps after only eight loads. It is therefore cheap to fill the whole array, including overlapping entries of different sizes that match the same address. That makes both the lowest-index priority and the pointer wrap easy to reach. Random runs mix loads of all four size codes with lookups aimed inside, and just beyond, each entry's range. This covers the masked compare at every offset width.

// File: rtl/mpx_tlb_pkg.sv
// Package for the translation buffer: the region size code, the stored
// entry record and the offset-mask helper. Assumes 32-bit addresses.
package mpx_tlb_pkg;

    localparam int VA_W = 32;

    typedef enum logic [1:0] {
        PG_4K  = 2'b00,
        PG_64K = 2'b01,
        PG_1M  = 2'b10,
        PG_16M = 2'b11
    } pg_size_e;

    typedef struct packed {
        logic              valid;
        pg_size_e          size;
        logic [VA_W-1:0]   vtag;
        logic [VA_W-1:0]   pbase;
    } tlb_ent_t;

    // Low-bit mask of the in-page offset for a size code.
    function automatic logic [VA_W-1:0] ofs_mask(pg_size_e s);
        case (s)
            PG_4K:   return 32'h0000_0FFF;
            PG_64K:  return 32'h0000_FFFF;
            PG_1M:   return 32'h000F_FFFF;
            PG_16M:  return 32'h00FF_FFFF;
            default: return 32'h0000_0FFF;
        endcase
    endfunction

endpackage

// File: rtl/tlb_slot.sv
// One translation entry: holds tag, base, size and valid, and compares the
// lookup address above its own offset. Assumes the write enable already
// excludes cycles with a global invalidate.
module tlb_slot
    import mpx_tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  tlb_ent_t        wr_ent,
    input  logic            inv_all,
    input  logic [VA_W-1:0] va,
    output logic            ent_valid,
    output logic            match,
    output logic [VA_W-1:0] xlat
);

    tlb_ent_t        ent_q;
    logic [VA_W-1:0] low_m;

    // Entry storage: reset and invalidate clear valid, a write loads all fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else if (inv_all) begin
            ent_q.valid <= 1'b0;
        end else if (wr_en) begin
            ent_q <= wr_ent;
        end
    end

    // Masked compare and address composition for this entry.
    always_comb begin
        low_m     = ofs_mask(ent_q.size);
        ent_valid = ent_q.valid;
        match     = ent_q.valid && (((va ^ ent_q.vtag) & ~low_m) == '0);
        xlat      = (ent_q.pbase & ~low_m) | (va & low_m);
    end

    // An invalidate leaves this entry without a valid bit.
    p_inv_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !ent_valid);

    // A write stores the requested valid bit.
    p_load_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_all) |=> (ent_valid == $past(wr_ent.valid)));

endmodule

// File: rtl/tlb_pick.sv
// Priority picker: returns the lowest matching index. Assumes N >= 2.
module tlb_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest match is written last.
    always_comb begin
        any = |match;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    // The chosen entry matches and no lower entry does.
    p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (match[idx] &&
                 ((match & ((({{(N-1){1'b0}}, 1'b1}) << idx) - 1'b1)) == '0)));

endmodule

// File: rtl/tlb_victim.sv
// Replacement pointer: round-robin advance on each accepted load, with a
// direct write that overrides the advance. Assumes N >= 2.
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    // Pointer update: direct write first, else wrap-around advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (set_en) begin
            ptr <= set_idx;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !set_en && ptr == LAST) |=> (ptr == '0));

    p_ptr_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (ptr == $past(set_idx)));

endmodule

// File: rtl/tlb_fault.sv
// Fault capture: a miss sets the interrupt and stores the address, unless
// a fault is already pending and not being cleared in the same cycle.
module tlb_fault
    import mpx_tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            miss,
    input  logic [VA_W-1:0] miss_va,
    input  logic            clr,
    output logic            irq,
    output logic [VA_W-1:0] addr
);

    // Sticky interrupt with first-fault address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            addr <= '0;
        end else if (miss && (!irq || clr)) begin
            irq  <= 1'b1;
            addr <= miss_va;
        end else if (clr) begin
            irq  <= 1'b0;
        end
    end

    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    p_fault_addr_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> $stable(addr));

    p_fault_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (irq && addr == $past(miss_va)) || $past(irq && !clr));

endmodule

// File: rtl/mpx_tlb.sv
// Top of the translation buffer: NUM_ENTRIES slots compared in parallel,
// lowest-index priority, round-robin loading and miss fault capture.
// Results are registered one cycle after the request.
module mpx_tlb
    import mpx_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [31:0]      ld_vtag,
    input  logic [31:0]      ld_pbase,
    input  logic [1:0]       ld_size,
    input  logic             ld_valid,
    input  logic             vp_wr_en,
    input  logic [IDX_W-1:0] vp_wr_idx,
    input  logic             inv_all,
    output logic [IDX_W-1:0] victim_ptr,
    input  logic             lk_req,
    input  logic [31:0]      lk_vaddr,
    output logic             lk_vld,
    output logic             lk_hit,
    output logic [31:0]      lk_paddr,
    output logic [IDX_W-1:0] lk_idx,
    output logic             fault_irq,
    output logic [31:0]      fault_addr,
    input  logic             fault_clr
);

    logic [NUM_ENTRIES-1:0] hit_vec;
    logic [NUM_ENTRIES-1:0] val_vec;
    logic [VA_W-1:0]        xlat_arr [NUM_ENTRIES];
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    logic                   load_go;
    tlb_ent_t               new_ent;

    // Load is dropped when an invalidate arrives in the same cycle.
    always_comb begin
        load_go = ld_en && !inv_all;
        new_ent = '{valid: ld_valid, size: pg_size_e'(ld_size),
                    vtag: ld_vtag, pbase: ld_pbase};
    end

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
            tlb_slot u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (load_go && (victim_ptr == IDX_W'(g))),
                .wr_ent    (new_ent),
                .inv_all   (inv_all),
                .va        (lk_vaddr),
                .ent_valid (val_vec[g]),
                .match     (hit_vec[g]),
                .xlat      (xlat_arr[g])
            );
        end
    endgenerate

    tlb_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .match (hit_vec),
        .any   (any_hit),
        .idx   (win_idx)
    );

    tlb_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (load_go),
        .set_en  (vp_wr_en),
        .set_idx (vp_wr_idx),
        .ptr     (victim_ptr)
    );

    tlb_fault u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .miss    (lk_req && !any_hit),
        .miss_va (lk_vaddr),
        .clr     (fault_clr),
        .irq     (fault_irq),
        .addr    (fault_addr)
    );

    // Result register: one-cycle answer to each lookup request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_vld   <= 1'b0;
            lk_hit   <= 1'b0;
            lk_paddr <= '0;
            lk_idx   <= '0;
        end else begin
            lk_vld <= lk_req;
            if (lk_req) begin
                lk_hit   <= any_hit;
                lk_paddr <= any_hit ? xlat_arr[win_idx] : '0;
                lk_idx   <= any_hit ? win_idx : '0;
            end
        end
    end

    p_miss_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && !lk_hit) |-> fault_irq);

    p_result_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && !$past(lk_req)) |-> 1'b0);

    p_inv_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (val_vec == '0));

endmodule

// File: tb/tb_mpx_tlb.sv
module tb_mpx_tlb;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_en, ld_valid, vp_wr_en, inv_all, lk_req, fault_clr;
    logic [31:0]   ld_vtag, ld_pbase, lk_vaddr;
    logic [1:0]    ld_size;
    logic [IW-1:0] vp_wr_idx;
    logic [IW-1:0] victim_ptr, lk_idx;
    logic          lk_vld, lk_hit, fault_irq;
    logic [31:0]   lk_paddr, fault_addr;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model of the array and state
    logic [31:0]   m_tag  [N];
    logic [31:0]   m_base [N];
    logic [1:0]    m_size [N];
    logic          m_val  [N];
    logic [IW-1:0] m_ptr;
    logic          m_irq;
    logic [31:0]   m_faddr;

    always #4 clk = ~clk;

    mpx_tlb #(.NUM_ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_vtag(ld_vtag), .ld_pbase(ld_pbase),
        .ld_size(ld_size), .ld_valid(ld_valid),
        .vp_wr_en(vp_wr_en), .vp_wr_idx(vp_wr_idx), .inv_all(inv_all),
        .victim_ptr(victim_ptr),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_idx(lk_idx),
        .fault_irq(fault_irq), .fault_addr(fault_addr), .fault_clr(fault_clr)
    );

    function automatic logic [31:0] lowm(input logic [1:0] s);
        return (32'h1 << (12 + 4 * s)) - 32'h1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ld_en = 0; ld_valid = 0; ld_vtag = 0; ld_pbase = 0; ld_size = 0;
        vp_wr_en = 0; vp_wr_idx = 0; inv_all = 0;
        lk_req = 0; lk_vaddr = 0; fault_clr = 0;
    endtask

    // Control cycle: load / pointer write / invalidate, then check the pointer.
    task automatic ctrl(input logic ld, input logic [31:0] tag, input logic [31:0] base,
                        input logic [1:0] sz, input logic v, input logic pw,
                        input logic [IW-1:0] pidx, input logic inv, input string req);
        @(negedge clk);
        ld_en = ld; ld_vtag = tag; ld_pbase = base; ld_size = sz; ld_valid = v;
        vp_wr_en = pw; vp_wr_idx = pidx; inv_all = inv;
        @(negedge clk);
        idle_inputs();
        if (inv) begin
            for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        end else if (ld) begin
            m_tag[m_ptr] = tag; m_base[m_ptr] = base;
            m_size[m_ptr] = sz; m_val[m_ptr] = v;
        end
        if (pw) m_ptr = pidx;
        else if (ld && !inv) m_ptr = (m_ptr == IW'(N - 1)) ? '0 : m_ptr + 1'b1;
        chk(req, 32'(victim_ptr), 32'(m_ptr));
    endtask

    // Lookup cycle with optional fault clear, compared against the model.
    task automatic look(input logic [31:0] va, input logic clr, input string req);
        logic          eh;
        logic [31:0]   ep;
        logic [IW-1:0] ei;
        eh = 0; ep = 0; ei = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_val[i] && (((va ^ m_tag[i]) & ~lowm(m_size[i])) == 0)) begin
                eh = 1; ei = IW'(i);
                ep = (m_base[i] & ~lowm(m_size[i])) | (va & lowm(m_size[i]));
            end
        end
        @(negedge clk);
        lk_req = 1; lk_vaddr = va; fault_clr = clr;
        @(negedge clk);
        idle_inputs();
        if (!eh && (!m_irq || clr)) begin
            m_irq = 1; m_faddr = va;
        end else if (clr) begin
            m_irq = 0;
        end
        chk({req, " vld"}, 32'(lk_vld), 32'd1);
        chk({req, " hit"}, 32'(lk_hit), 32'(eh));
        chk({req, " paddr"}, lk_paddr, ep);
        chk({req, " idx"}, 32'(lk_idx), 32'(ei));
        chk({req, " irq"}, 32'(fault_irq), 32'(m_irq));
        chk({req, " faddr"}, fault_addr, m_faddr);
    endtask

    task automatic clear_fault();
        @(negedge clk);
        fault_clr = 1;
        @(negedge clk);
        idle_inputs();
        m_irq = 0;
        chk("R10 clear", 32'(fault_irq), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        idle_inputs();
        rst_n = 0;
        for (int i = 0; i < N; i++) begin
            m_tag[i] = 0; m_base[i] = 0; m_size[i] = 0; m_val[i] = 0;
        end
        m_ptr = 0; m_irq = 0; m_faddr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ptr", 32'(victim_ptr), 32'd0);
        chk("R1 irq", 32'(fault_irq), 32'd0);
        chk("R1 vld", 32'(lk_vld), 32'd0);
        look(32'h1234_5678, 0, "R1 empty miss");
        clear_fault();

        // R2/R3: one entry per size code
        ctrl(1, 32'h1000_0000, 32'hA000_0000, 2'b00, 1, 0, 0, 0, "R6 load0");
        ctrl(1, 32'h2000_0000, 32'hB000_0000, 2'b01, 1, 0, 0, 0, "R6 load1");
        ctrl(1, 32'h3000_0000, 32'hC000_0000, 2'b10, 1, 0, 0, 0, "R6 load2");
        ctrl(1, 32'h4000_0000, 32'hD000_0000, 2'b11, 1, 0, 0, 0, "R6 load3");
        look(32'h1000_0FFF, 0, "R2 4K top hit R3");
        look(32'h1000_1000, 0, "R2 4K next miss R9");
        look(32'h2000_ABCD, 0, "R2 64K hit R10 pending");
        look(32'h2001_0000, 0, "R2 64K next miss R10 keep");
        look(32'h300F_FFFF, 1, "R2 1M hit clr");
        look(32'h40FF_0001, 0, "R2 16M hit R3");
        look(32'h4100_0000, 1, "R10 miss with clr R9");
        clear_fault();

        // R5: overlapping entries, lower index wins
        ctrl(1, 32'h4012_3000, 32'hE000_0000, 2'b00, 1, 0, 0, 0, "R6 load4");
        look(32'h4012_3456, 0, "R5 lowest wins");
        ctrl(0, 0, 0, 0, 0, 1, 3'd2, 0, "R7 set ptr");
        ctrl(1, 32'h4012_3000, 32'hF000_0000, 2'b00, 1, 0, 0, 0, "R5 load at2");
        look(32'h4012_3456, 0, "R5 idx2 beats idx3");

        // R11: invalid entry never hits
        ctrl(1, 32'h5000_0000, 32'h1111_0000, 2'b11, 0, 0, 0, 0, "R11 load inv");
        look(32'h5000_0010, 0, "R11 no hit");
        clear_fault();

        // R7: load with pointer write, R6 wrap
        ctrl(1, 32'h6000_0000, 32'h2222_0000, 2'b01, 1, 1, 3'd7, 0, "R7 load+set");
        look(32'h6000_0004, 0, "R7 old slot used");
        ctrl(1, 32'h7000_0000, 32'h3333_0000, 2'b00, 1, 0, 0, 0, "R6 wrap to 0");

        // R8: invalidate with simultaneous load
        ctrl(1, 32'h8000_0000, 32'h4444_0000, 2'b00, 1, 0, 0, 1, "R8 inv drops load");
        look(32'h7000_0000, 0, "R8 all invalid");
        look(32'h8000_0000, 0, "R8 dropped load");
        clear_fault();

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                ctrl(1, $urandom, $urandom, 2'($urandom_range(0, 3)),
                     ($urandom_range(0, 7) != 0), ($urandom_range(0, 9) == 0),
                     IW'($urandom), 0, "R6 rand load");
            end else if (op == 3 && $urandom_range(0, 7) == 0) begin
                ctrl(0, 0, 0, 0, 0, 0, 0, 1, "R8 rand inv");
            end else begin
                int j;
                logic [31:0] va;
                j = $urandom_range(0, N - 1);
                case ($urandom_range(0, 2))
                    0: va = (m_tag[j] & ~lowm(m_size[j])) | ($urandom & lowm(m_size[j]));
                    1: va = (m_tag[j] & ~lowm(m_size[j])) + lowm(m_size[j]) + 32'h1;
                    default: va = $urandom;
                endcase
                look(va, ($urandom_range(0, 3) == 0), "R2 R5 R10 rand look");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule